// File: doc/BRIEF.md
# Synchronous Character Transmitter with Fill and Escape Stuffing

This block is the transmit half of a character-oriented synchronous serial controller. A host places characters one at a time into a single holding register; the block moves each one into a shift register and sends it on `txd`, least significant bit first. If parity is on, a parity bit follows the data. Serialization moves forward only on a one-cycle `bit_tick` pulse, which comes from an external bit-rate source. A synchronous line may not go quiet in the middle of a message. So when the host runs late, the block sends fill characters, built from the programmed SYN1, SYN2 and escape (DLE) characters, until the host writes new data.

In transparent mode, any escape character the host writes goes out twice, so the far end can tell it apart from control sequences. A one-shot command puts the escape character in front of the next host character. The line is gated by the clear-to-send input and by the enable. A character already in the shift register always completes before the line rests at mark. The request-to-send output is held after its control bit drops, and only released once nothing is left to send.

Top module: `bisync_tx`

## Requirements
- R1: After reset the outputs are `txd`=1, `tx_ready`=0 (with `tx_en`=0), `tx_empty`=0 and `rts_out`=0.
- R2: After `tx_en` rises, `txd` stays at 1 across bit ticks until the first host write, and `tx_ready` is 1 during that time.
- R3: A character is sent least significant bit first, one bit per tick. Its length is 5 + `char_len` bits (`char_len` 0..3 gives 5..8 bits), and the data bits above that length are not sent.
- R4: With `par_en`=1, one extra bit follows the data. With `par_odd`=0 it makes the count of ones in data plus parity even; with `par_odd`=1 it makes that count odd.
- R5: When a character finishes and the holding register is empty, fill follows with no gap. The fill is SYN1 when `single_syn`=1 and `transparent`=0, SYN1 then SYN2 when `single_syn`=0 and `transparent`=0, and DLE then SYN1 when `transparent`=1. A two-character fill always completes before data resumes.
- R6: `tx_empty` rises on the tick that starts fill (so only after at least one character has been sent), and it clears in the cycle after a host write.
- R7: A `send_dle` pulse makes the DLE character go out just before the next host character. The command is used once and then clears itself: a later host character is sent without a DLE in front.
- R8: With `transparent`=1, a host character equal to DLE (compared over the character length) is sent twice. If that DLE was already preceded by a `send_dle` insertion, no further copy is added.
- R9: `tx_ready` drops in the cycle after a host write and rises again on the tick that moves the character into the shift register.
- R10: If `cts_n` goes high or `tx_en` goes low while a character is being sent, that character still completes, and `txd` then stays at 1.
- R11: While `rts_req`=1, `rts_out` is 1. After `rts_req` falls, `rts_out` stays 1 until both the holding register and the shift register are empty, and it falls one bit tick after the shift register goes empty.
- R12: `txd` changes only in cycles that follow a `bit_tick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| cts_n | input | 1 | Clear to send, low active |
| rts_req | input | 1 | Request-to-send control bit |
| send_dle | input | 1 | One-shot pulse: insert DLE before the next character |
| char_len | input | 2 | Character length minus five |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| single_syn | input | 1 | 1 = single SYN fill, 0 = SYN1 then SYN2 fill |
| transparent | input | 1 | Transparent mode: DLE-SYN1 fill and DLE doubling |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| dle | input | 8 | Escape character |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Host character |
| txd | output | 1 | Serial output, mark = 1 |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Underrun: fill is being sent |
| rts_out | output | 1 | Request to send, high active |

## Verification
The assertions assume that `wr_stb` and `send_dle` are single-cycle strobes, and that the format inputs (`char_len`, parity, fill mode and the three special characters) do not change while a character is being sent. The stimulus changes the format only after the transmitter has been disabled and enough ticks have passed for the shift register to drain. Every write and command pulse lasts exactly one cycle and is placed between ticks, never on a tick. Ticks come every other cycle, except for one stretch with no ticks that tests that the line holds its value between ticks.

// File: rtl/bisync_tx.sv
module bisync_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         tx_en,
  input  logic         cts_n,
  input  logic         rts_req,
  input  logic         send_dle,
  input  logic [1:0]   char_len,
  input  logic         par_en,
  input  logic         par_odd,
  input  logic         single_syn,
  input  logic         transparent,
  input  logic [W-1:0] syn1,
  input  logic [W-1:0] syn2,
  input  logic [W-1:0] dle,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  output logic         txd,
  output logic         tx_ready,
  output logic         tx_empty,
  output logic         rts_out
);
  localparam int CW = $clog2(W + 2);

  logic [W-1:0] hold_q, aft_c, sel_c, dmask, aft_n;
  logic [W:0]   sh_q, frame;
  logic [CW-1:0] cnt_q, dlen, nbits;
  logic hold_full, busy_q, txd_q, started_q, dle_pend_q, dle_sent_q;
  logic aft_v, empty_q, rts_q, sent_any_q;
  logic active, boundary, load, xfer, use_dle, set_aft, pbit;

  assign active   = tx_en & ~cts_n & started_q;
  assign boundary = bit_tick & (cnt_q == '0);
  assign dlen     = CW'(5) + CW'(char_len);
  assign nbits    = dlen + CW'(par_en);
  assign dmask    = {W{1'b1}} >> (CW'(W) - dlen);
  assign pbit     = (^(sel_c & dmask)) ^ par_odd;
  assign frame    = {1'b0, sel_c & dmask} | ((W+1)'(pbit & par_en) << dlen);

  always_comb begin
    load = 1'b0; xfer = 1'b0; use_dle = 1'b0; set_aft = 1'b0;
    sel_c = '0; aft_n = '0;
    if (boundary && active) begin
      load = 1'b1;
      if (aft_v) begin
        sel_c = aft_c;
      end else if (hold_full && dle_pend_q) begin
        sel_c = dle; use_dle = 1'b1;
      end else if (hold_full) begin
        sel_c = hold_q; xfer = 1'b1;
        if (transparent && ((hold_q & dmask) == (dle & dmask)) && !dle_sent_q) begin
          set_aft = 1'b1; aft_n = dle;
        end
      end else if (transparent) begin
        sel_c = dle; set_aft = 1'b1; aft_n = syn1;
      end else begin
        sel_c = syn1;
        if (!single_syn) begin
          set_aft = 1'b1; aft_n = syn2;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1; sh_q <= '0; cnt_q <= '0; busy_q <= 1'b0;
      aft_v <= 1'b0; aft_c <= '0;
    end else if (load) begin
      txd_q <= frame[0]; sh_q <= frame >> 1; cnt_q <= nbits - CW'(1);
      busy_q <= 1'b1; aft_v <= set_aft; aft_c <= aft_n;
    end else if (bit_tick && cnt_q != '0) begin
      txd_q <= sh_q[0]; sh_q <= sh_q >> 1; cnt_q <= cnt_q - CW'(1);
    end else if (boundary) begin
      txd_q <= 1'b1; busy_q <= 1'b0; aft_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; hold_full <= 1'b0; started_q <= 1'b0;
      dle_pend_q <= 1'b0; dle_sent_q <= 1'b0; sent_any_q <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      if (wr_stb) hold_q <= wr_data;
      hold_full  <= (hold_full & ~xfer) | wr_stb;
      started_q  <= tx_en & (started_q | wr_stb);
      dle_pend_q <= (dle_pend_q & ~use_dle) | send_dle;
      if (use_dle) dle_sent_q <= 1'b1;
      else if (xfer) dle_sent_q <= 1'b0;
      if (load) sent_any_q <= 1'b1;
      if (wr_stb) empty_q <= 1'b0;
      else if (boundary && !hold_full && sent_any_q) empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else if (rts_req) rts_q <= 1'b1;
    else if (bit_tick && !busy_q && !hold_full && !load) rts_q <= 1'b0;
  end

  assign txd      = txd_q;
  assign tx_ready = tx_en & ~hold_full;
  assign tx_empty = empty_q;
  assign rts_out  = rts_q;
endmodule

// File: rtl/bisync_tx_chk.sv
module bisync_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_stb,
  input logic tx_en,
  input logic rts_req,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty,
  input logic rts_out,
  input logic busy_q,
  input logic hold_full
);
  AST_TXD_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd)); // R12
  AST_RDY_DROP_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en) |=> !tx_ready); // R9
  AST_EMPTY_CLR_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !tx_empty); // R6
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd); // R10
  AST_RTS_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rts_req |=> rts_out); // R11
  AST_RTS_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_out && hold_full) |=> rts_out); // R11
endmodule

bind bisync_tx bisync_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb),
  .tx_en(tx_en), .rts_req(rts_req), .txd(txd), .tx_ready(tx_ready),
  .tx_empty(tx_empty), .rts_out(rts_out), .busy_q(busy_q),
  .hold_full(hold_full)
);

// File: tb/test_bisync_tx.sv
module test_bisync_tx;
  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, tx_en = 1'b0, cts_n = 1'b0;
  logic rts_req = 1'b0, send_dle = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic single_syn = 1'b1, transparent = 1'b0, wr_stb = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic [7:0] syn1 = 8'h16, syn2 = 8'h3A, dle = 8'h10, wr_data = 8'h00;
  logic txd, tx_ready, tx_empty, rts_out;
  int n_chk = 0, n_bad = 0;
  logic [31:0] got;
  logic b;

  always #2 clk = ~clk;

  bisync_tx i_bisync_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .cts_n(cts_n),
    .rts_req(rts_req), .send_dle(send_dle), .char_len(char_len), .par_en(par_en),
    .par_odd(par_odd), .single_syn(single_syn), .transparent(transparent),
    .syn1(syn1), .syn2(syn2), .dle(dle), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .rts_out(rts_out)
  );

  // data, char_len, par_en, par_odd
  localparam logic [11:0] VEC [6] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0},
    {8'hFF, 2'd0, 1'b0, 1'b0},
    {8'h6C, 2'd1, 1'b1, 1'b0},
    {8'h6C, 2'd1, 1'b1, 1'b1},
    {8'h7B, 2'd2, 1'b1, 1'b0},
    {8'h81, 2'd3, 1'b1, 1'b1}
  };

  function automatic logic [31:0] frame_of(logic [7:0] d, logic [1:0] len, logic pe, logic po);
    int n = 5 + int'(len);
    logic [7:0] m = 8'((1 << n) - 1);
    logic [7:0] dd = d & m;
    logic p = (^dd) ^ po;
    return pe ? (32'(dd) | (32'(p) << n)) : 32'(dd);
  endfunction

  function automatic int nb(logic [1:0] len, logic pe);
    return 5 + int'(len) + int'(pe);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(output logic bit_o);
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    bit_o = txd;
  endtask

  task automatic recv(input int n, output logic [31:0] v);
    logic bb;
    v = '0;
    for (int i = 0; i < n; i++) begin
      tick(bb);
      v[i] = bb;
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
    @(negedge clk) wr_stb = 1'b0;
  endtask

  task automatic pulse_dle();
    @(negedge clk) send_dle = 1'b1;
    @(negedge clk) send_dle = 1'b0;
  endtask

  task automatic stop_tx();
    logic bb;
    @(negedge clk) tx_en = 1'b0;
    for (int i = 0; i < 12; i++) tick(bb);
  endtask

  task automatic start_tx();
    @(negedge clk) tx_en = 1'b1;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 txd", 32'(txd), 1);
    check("R1 ready", 32'(tx_ready), 0);
    check("R1 empty", 32'(tx_empty), 0);
    check("R1 rts", 32'(rts_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 idle mark until first write
    start_tx();
    recv(6, got);
    check("R2 idle line", got, 32'h3F);
    check("R2 ready", 32'(tx_ready), 1);
    stop_tx();

    // R3 R4 table of formats
    for (int k = 0; k < 6; k++) begin
      char_len = VEC[k][3:2]; par_en = VEC[k][1]; par_odd = VEC[k][0];
      start_tx();
      host_wr(VEC[k][11:4]);
      recv(nb(VEC[k][3:2], VEC[k][1]), got);
      check($sformatf("R3 R4 vector %0d", k), got,
            frame_of(VEC[k][11:4], VEC[k][3:2], VEC[k][1], VEC[k][0]));
      stop_tx();
    end
    char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0;

    // R9 R6 R5 single SYN fill, empty flag
    start_tx();
    host_wr(8'hC3);
    check("R9 ready low after write", 32'(tx_ready), 0);
    tick(b);
    got = 32'(b);
    check("R9 ready at transfer", 32'(tx_ready), 1);
    check("R6 empty during char", 32'(tx_empty), 0);
    for (int i = 1; i < 8; i++) begin tick(b); got[i] = b; end
    check("R3 first char", got, 32'hC3);
    recv(8, got);
    check("R6 empty on fill", 32'(tx_empty), 1);
    check("R5 single fill", got, 32'h16);
    host_wr(8'h5E);
    check("R6 empty cleared by write", 32'(tx_empty), 0);
    recv(8, got);
    check("R5 data resumes", got, 32'h5E);
    stop_tx();

    // R5 double SYN fill
    single_syn = 1'b0;
    start_tx();
    host_wr(8'h11);
    recv(8, got); check("R5 dbl data", got, 32'h11);
    recv(8, got); check("R5 dbl syn1", got, 32'h16);
    recv(8, got); check("R5 dbl syn2", got, 32'h3A);
    recv(8, got); check("R5 dbl syn1 again", got, 32'h16);
    stop_tx();
    single_syn = 1'b1;

    // R5 transparent fill
    transparent = 1'b1;
    start_tx();
    host_wr(8'h22);
    recv(8, got); check("R5 tr data", got, 32'h22);
    recv(8, got); check("R5 tr fill dle", got, 32'h10);
    recv(8, got); check("R5 tr fill syn1", got, 32'h16);
    stop_tx();

    // R8 DLE doubling
    start_tx();
    host_wr(8'h10);
    recv(8, got); check("R8 dle data", got, 32'h10);
    recv(8, got); check("R8 stuffed dle", got, 32'h10);
    recv(8, got); check("R8 fill dle", got, 32'h10);
    recv(8, got); check("R8 fill syn1", got, 32'h16);
    stop_tx();

    // R8 send-DLE plus DLE data adds only one extra
    start_tx();
    pulse_dle();
    host_wr(8'h10);
    recv(8, got); check("R8 cmd dle", got, 32'h10);
    recv(8, got); check("R8 data dle", got, 32'h10);
    recv(8, got); check("R8 fill dle after single extra", got, 32'h10);
    recv(8, got); check("R8 fill syn1 after single extra", got, 32'h16);
    stop_tx();
    transparent = 1'b0;

    // R7 send-DLE one-shot
    start_tx();
    pulse_dle();
    host_wr(8'h55);
    recv(8, got); check("R7 inserted dle", got, 32'h10);
    recv(8, got); check("R7 data after dle", got, 32'h55);
    host_wr(8'h33);
    recv(8, got); check("R7 no second dle", got, 32'h33);
    stop_tx();

    // R10 CTS high mid-character
    start_tx();
    host_wr(8'h96);
    recv(3, got);
    @(negedge clk) cts_n = 1'b1;
    for (int i = 3; i < 8; i++) begin tick(b); got[i] = b; end
    check("R10 char completes on cts", got, 32'h96);
    recv(3, got);
    check("R10 mark after cts", got, 32'h7);
    stop_tx();
    cts_n = 1'b0;

    // R12 no tick, no change
    start_tx();
    host_wr(8'h0E);
    tick(b);
    check("R12 first bit", 32'(b), 0);
    repeat (20) @(negedge clk);
    check("R12 stable without tick", 32'(txd), 0);
    recv(7, got);
    check("R12 rest of char", got, 32'h07);
    stop_tx();

    // R11 RTS release and R10 disable mid-character
    @(negedge clk) rts_req = 1'b1;
    @(negedge clk);
    check("R11 rts on", 32'(rts_out), 1);
    start_tx();
    host_wr(8'h3C);
    tick(b);
    got = 32'(b);
    @(negedge clk) begin rts_req = 1'b0; tx_en = 1'b0; end
    for (int i = 1; i < 8; i++) begin tick(b); got[i] = b; end
    check("R10 char completes on disable", got, 32'h3C);
    check("R11 rts held during char", 32'(rts_out), 1);
    tick(b);
    check("R11 rts held one bit after", 32'(rts_out), 1);
    check("R10 mark after disable", 32'(b), 1);
    tick(b);
    check("R11 rts released", 32'(rts_out), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule